// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits between a host register interface and an external engine that drives the pins of an enhanced parallel port. It holds the port's control register. It decides, from that register alone, whether a host access to the address register (offset 3) or the data register (offset 4) may start a bus cycle. When a cycle may start, the block hands it to the engine over a level request and waits for a one-cycle acknowledge or error pulse. An engine error sets a sticky timeout flag. That flag appears in bit 0 of every status read and is cleared by a status write.

Data accesses can be one, two or four bytes wide, and the bytes go to and from the engine in little-endian order. The address register always moves a single byte. A read that is not allowed to start, or that the engine fails, returns all ones at the access width. The host sees `host_ready` low for as long as a cycle is outstanding. Register reads return their data through a registered response pulse.

The controller has two states. In `ST_IDLE` the block accepts an access. The transition `LAUNCH` (an access to offset 3 or 4 whose control pattern passes the gate) moves it to `ST_BUSY`. Every other access completes within `ST_IDLE`. In `ST_BUSY` the engine request is held high. The transition `FINISH` (engine acknowledge or error) returns the block to `ST_IDLE`.

Top module: `epp_gate`

## Requirements
- R1: After reset, the control value is 0x0C, the timeout flag is clear, `host_ready` is 1 and `eng_req` is 0.
- R2: A write to offset 3 or 4 starts an engine cycle only when (control & 0x2F) == 0x04. In every other case the write starts nothing and `host_ready` stays 1.
- R3: A read from offset 3 or 4 starts an engine cycle only when (control & 0x2F) == 0x24. Bit 5 of the control value is the direction bit, and 1 means read.
- R4: A read at offset 3 or 4 that the gate refuses returns all ones at the access width one cycle after it is accepted. The widths give 0xFF, 0xFFFF or 0xFFFFFFFF.
- R5: While a cycle is outstanding, `eng_req` stays 1 and `host_ready` stays 0 until `eng_ack` or `eng_err` is seen. For a read, `rsp_valid` pulses in the cycle after that edge.
- R6: An engine error sets the timeout flag, and the flag stays set. A failed read returns all ones at the access width.
- R7: A read of offset 1 returns `ext_status` with bit 0 replaced by the timeout flag.
- R8: A write to offset 1 with bit 0 set clears the timeout flag. With bit 0 clear, the write leaves the flag unchanged.
- R9: `host_size` sets the data width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Accesses to offset 3 always use 1 byte. Byte k of the host word is engine lane k (bits 8k+7:8k), `eng_nbytes` gives the count, and unused lanes are zero in both directions.
- R10: A control write (offset 2) whose value equals the held value is ignored and gives no `ctl_upd` pulse. A differing value updates `ctl_q` and pulses `ctl_upd` for one cycle.
- R11: A control write that flips bit 5 pulses `dir_chg` for one cycle, and `ctl_q[5]` then holds the new direction.
- R12: A read of offset 2 returns the held control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Access request, taken when `host_ready` is 1 |
| host_write | input | 1 | 1 write, 0 read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Width code for data accesses |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Block can accept an access |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 32 | Read data |
| ext_status | input | 8 | Status lines from the port |
| ctl_q | output | 8 | Held control value |
| ctl_upd | output | 1 | Control value changed pulse |
| dir_chg | output | 1 | Direction bit changed pulse |
| eng_req | output | 1 | Cycle request to engine |
| eng_is_addr | output | 1 | Cycle targets the address register |
| eng_write | output | 1 | Cycle direction, 1 write |
| eng_nbytes | output | 3 | Bytes in the cycle |
| eng_wdata | output | 32 | Write bytes, lane k is byte k |
| eng_ack | input | 1 | Cycle done pulse |
| eng_err | input | 1 | Cycle failed pulse |
| eng_rdata | input | 32 | Read bytes, lane k is byte k |

## Verification
Register reads and refused reads are due in the first cycle after the accepting edge. `ctl_upd`, `dir_chg` and the start of `eng_req` appear at that same point. Launched reads respond one cycle after the edge that samples the engine's acknowledge or error. The bench drives and samples on the falling edge. Every expected read value is pushed into the scoreboard before its access, so the monitor pops it exactly when `rsp_valid` rises. Port checks on the engine side and on the pulses are taken at the first falling edge after the edge that should produce them.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
    localparam int BYTE_W    = 8;
    localparam int CTL_W     = 8;
    localparam int OFS_STAT  = 1;
    localparam int OFS_CTL   = 2;
    localparam int OFS_EADDR = 3;
    localparam int OFS_EDATA = 4;
    localparam logic [CTL_W-1:0] GATE_MASK = 8'h2F;
    localparam logic [CTL_W-1:0] WR_PAT    = 8'h04;
    localparam logic [CTL_W-1:0] RD_PAT    = 8'h24;
    localparam logic [CTL_W-1:0] CTL_RST   = 8'h0C;
    localparam int DIR_BIT = 5;

    typedef enum logic {ST_IDLE, ST_BUSY} gate_st_e;
endpackage

// File: rtl/epp_gate_chk.sv
module epp_gate_chk
    import epp_gate_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    output logic             wr_ok,
    output logic             rd_ok
);
    logic [CTL_W-1:0] sig;
    assign sig   = ctl & GATE_MASK;
    assign wr_ok = (sig == WR_PAT);
    assign rd_ok = (sig == RD_PAT);
endmodule

// File: rtl/epp_lane_fmt.sv
module epp_lane_fmt
    import epp_gate_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / BYTE_W,
    localparam int NB_W  = $clog2(NLANE) + 1
) (
    input  logic [NB_W-1:0]   nbytes,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dmask,
    output logic [DATA_W-1:0] ones
);
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic en;
        assign en = (NB_W'(k) < nbytes);
        assign dmask[k*BYTE_W +: BYTE_W] = en ? din[k*BYTE_W +: BYTE_W] : '0;
        assign ones[k*BYTE_W +: BYTE_W]  = en ? '1 : '0;
    end
endmodule

// File: rtl/epp_gate.sv
module epp_gate
    import epp_gate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    localparam int NLANE = DATA_W / BYTE_W,
    localparam int NB_W  = $clog2(NLANE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic [CTL_W-1:0]  ext_status,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              ctl_upd,
    output logic              dir_chg,
    output logic              eng_req,
    output logic              eng_is_addr,
    output logic              eng_write,
    output logic [NB_W-1:0]   eng_nbytes,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_ack,
    input  logic              eng_err,
    input  logic [DATA_W-1:0] eng_rdata
);
    gate_st_e state_q, state_d;
    logic     to_q;
    logic     wr_ok, rd_ok;
    logic     accept, is_addr, is_data, is_epp, gate_pass, finish;
    logic [NB_W-1:0]   acc_nbytes;
    logic [DATA_W-1:0] acc_wdata, acc_ones, eng_rmask, eng_ones;
    logic [CTL_W-1:0]  stat_view;

    epp_gate_chk u_chk (.ctl(ctl_q), .wr_ok(wr_ok), .rd_ok(rd_ok));

    epp_lane_fmt #(.DATA_W(DATA_W)) u_host_fmt (
        .nbytes(acc_nbytes), .din(host_wdata), .dmask(acc_wdata), .ones(acc_ones));

    epp_lane_fmt #(.DATA_W(DATA_W)) u_eng_fmt (
        .nbytes(eng_nbytes), .din(eng_rdata), .dmask(eng_rmask), .ones(eng_ones));

    assign accept    = host_valid && (state_q == ST_IDLE);
    assign is_addr   = (host_addr == ADDR_W'(OFS_EADDR));
    assign is_data   = (host_addr == ADDR_W'(OFS_EDATA));
    assign is_epp    = is_addr || is_data;
    assign gate_pass = is_epp && (host_write ? wr_ok : rd_ok);
    assign finish    = eng_ack || eng_err;
    assign stat_view = (ext_status & ~CTL_W'(1)) | CTL_W'(to_q);

    always_comb begin
        if (is_addr) begin
            acc_nbytes = NB_W'(1);
        end else begin
            unique case (host_size)
                2'd0:    acc_nbytes = NB_W'(1);
                2'd1:    acc_nbytes = NB_W'(2);
                default: acc_nbytes = NB_W'(NLANE);
            endcase
        end
    end

    // next-state logic: LAUNCH and FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && gate_pass) state_d = ST_BUSY;
            ST_BUSY: if (finish)              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign host_ready = (state_q == ST_IDLE);
    assign eng_req    = (state_q == ST_BUSY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= CTL_RST;
            to_q        <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            ctl_upd     <= 1'b0;
            dir_chg     <= 1'b0;
            eng_is_addr <= 1'b0;
            eng_write   <= 1'b0;
            eng_nbytes  <= NB_W'(1);
            eng_wdata   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            ctl_upd   <= 1'b0;
            dir_chg   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (host_addr == ADDR_W'(OFS_STAT)) begin
                            if (host_write) begin
                                if (host_wdata[0]) to_q <= 1'b0;
                            end else begin
                                rsp_valid <= 1'b1;
                                rsp_data  <= DATA_W'(stat_view);
                            end
                        end else if (host_addr == ADDR_W'(OFS_CTL)) begin
                            if (host_write) begin
                                if (host_wdata[CTL_W-1:0] != ctl_q) begin
                                    ctl_q   <= host_wdata[CTL_W-1:0];
                                    ctl_upd <= 1'b1;
                                    dir_chg <= host_wdata[DIR_BIT] != ctl_q[DIR_BIT];
                                end
                            end else begin
                                rsp_valid <= 1'b1;
                                rsp_data  <= DATA_W'(ctl_q);
                            end
                        end else if (gate_pass) begin
                            eng_is_addr <= is_addr;
                            eng_write   <= host_write;
                            eng_nbytes  <= acc_nbytes;
                            eng_wdata   <= host_write ? acc_wdata : '0;
                        end else if (!host_write) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= acc_ones;
                        end
                    end
                end
                ST_BUSY: begin
                    if (finish) begin
                        if (eng_err) to_q <= 1'b1;
                        if (!eng_write) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= eng_err ? eng_ones : eng_rmask;
                        end
                    end
                end
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_ack && !eng_err |=> eng_req); // R5
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !host_ready); // R5
    AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> $past(host_write ? wr_ok : rd_ok)); // R2
    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_err |=> to_q); // R6
    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_q) |-> $past(host_valid && host_write && host_wdata[0]
                              && host_addr == ADDR_W'(OFS_STAT))); // R8
    AST_CTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_upd |-> ctl_q != $past(ctl_q)); // R10
    AST_DIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_chg |-> ctl_q[DIR_BIT] != $past(ctl_q[DIR_BIT])); // R11
endmodule

// File: tb/epp_gate_tb.sv
`timescale 1ns/1ps
module epp_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic [7:0]  ext_status = 8'hDE;
    logic [7:0]  ctl_q;
    logic        ctl_upd, dir_chg, eng_req, eng_is_addr, eng_write;
    logic [2:0]  eng_nbytes;
    logic [31:0] eng_wdata;
    logic        eng_ack = 1'b0, eng_err = 1'b0;
    logic [31:0] eng_rdata = '0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // engine model
    bit          fail_next = 0;
    int          cnt = 0, launches = 0;
    logic        cap_addr, cap_wr;
    logic [2:0]  cap_nb;
    logic [31:0] cap_wd;

    always #2.5 clk = ~clk;

    epp_gate dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        eng_ack = 1'b0;
        eng_err = 1'b0;
        if (rst_n && eng_req) begin
            if (cnt == 0) begin
                launches++;
                cap_addr = eng_is_addr; cap_wr = eng_write;
                cap_nb = eng_nbytes; cap_wd = eng_wdata;
            end
            if (cnt == 2) begin
                if (fail_next) eng_err = 1'b1; else eng_ack = 1'b1;
                cnt = 0;
            end else cnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected response actual=%h expected=none", rsp_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rsp_data, e);
            end
        end
    end

    task automatic access(bit wr, logic [2:0] a, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = a; host_size = sz; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic rd_expect(logic [2:0] a, logic [1:0] sz, logic [31:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        access(0, a, sz, 0);
        @(negedge clk);
    endtask

    task automatic ctl_wr(logic [7:0] v, bit e_upd, bit e_dir, string tag);
        access(1, 3'd2, 0, {24'h0, v});
        chk({tag, " ctl_upd"}, ctl_upd, e_upd);
        chk({tag, " dir_chg"}, dir_chg, e_dir);
        chk({tag, " ctl_q"}, ctl_q, v);
    endtask

    task automatic gated_wr(logic [2:0] a, logic [1:0] sz, string tag);
        int l0;
        l0 = launches;
        access(1, a, sz, 32'h55AA55AA);
        chk({tag, " ready"}, host_ready, 1);
        @(negedge clk);
        chk({tag, " no launch"}, launches, l0);
    endtask

    task automatic launched(bit wr, logic [2:0] a, logic [1:0] sz, logic [31:0] d,
                            bit e_addr, logic [2:0] e_nb, logic [31:0] e_wd, string tag);
        int l0, guard;
        l0 = launches;
        access(wr, a, sz, d);
        chk({tag, " R5 ready low"}, host_ready, 0);
        chk({tag, " R5 req high"}, eng_req, 1);
        guard = 0;
        while (!host_ready && guard < 20) begin @(negedge clk); guard++; end
        chk({tag, " launch"}, launches, l0 + 1);
        chk({tag, " R9 is_addr"}, cap_addr, e_addr);
        chk({tag, " write"}, cap_wr, wr);
        chk({tag, " R9 nbytes"}, cap_nb, e_nb);
        if (wr) chk({tag, " R9 wdata"}, cap_wd, e_wd);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctl reset", ctl_q, 8'h0C);
        chk("R1 ready", host_ready, 1);
        chk("R1 req", eng_req, 0);
        rd_expect(3'd1, 0, 32'hDE, "R1 R7 status no timeout");
        rd_expect(3'd2, 0, 32'h0C, "R12 control read");
        gated_wr(3'd4, 0, "R2 write at reset pattern");
        rd_expect(3'd4, 0, 32'hFF, "R4 gated read 8");
        ctl_wr(8'h0C, 0, 0, "R10 equal write");
        ctl_wr(8'h04, 1, 0, "R10 change");
        launched(1, 3'd3, 2, 32'h123456A5, 1, 3'd1, 32'hA5, "R2 addr write");
        launched(1, 3'd4, 1, 32'h1234BEEF, 0, 3'd2, 32'h0000BEEF, "R2 data16 write");
        launched(1, 3'd4, 2, 32'hCAFEF00D, 0, 3'd4, 32'hCAFEF00D, "R2 data32 write");
        launched(1, 3'd4, 3, 32'h01020304, 0, 3'd4, 32'h01020304, "R9 size3 write");
        rd_expect(3'd4, 1, 32'hFFFF, "R3 R4 read in write mode 16");
        ctl_wr(8'h24, 1, 1, "R11 to read");
        gated_wr(3'd3, 0, "R2 write in read mode");
        eng_rdata = 32'h89ABCDEF;
        exp_q.push_back(32'h89ABCDEF); tag_q.push_back("R3 R9 read32");
        launched(0, 3'd4, 2, 0, 0, 3'd4, 0, "R3 read32");
        exp_q.push_back(32'h0000CDEF); tag_q.push_back("R9 read16");
        launched(0, 3'd4, 1, 0, 0, 3'd2, 0, "R9 read16");
        exp_q.push_back(32'h000000EF); tag_q.push_back("R9 addr read");
        launched(0, 3'd3, 2, 0, 1, 3'd1, 0, "R9 addr read");
        fail_next = 1;
        exp_q.push_back(32'hFFFFFFFF); tag_q.push_back("R6 failed read32");
        launched(0, 3'd4, 2, 0, 0, 3'd4, 0, "R6 failed read");
        fail_next = 0;
        rd_expect(3'd1, 0, 32'hDF, "R6 R7 status timeout set");
        access(1, 3'd1, 0, 32'h0);
        rd_expect(3'd1, 0, 32'hDF, "R8 write bit0 clear keeps flag");
        access(1, 3'd1, 0, 32'h1);
        rd_expect(3'd1, 0, 32'hDE, "R8 clear");
        ctl_wr(8'h2C, 1, 0, "R10 select set");
        rd_expect(3'd4, 2, 32'hFFFFFFFF, "R3 R4 gated read32");
        rd_expect(3'd2, 0, 32'h2C, "R12 control read back");
        ctl_wr(8'h04, 1, 1, "R11 to write");
        fail_next = 1;
        launched(1, 3'd4, 0, 32'h77, 0, 3'd1, 32'h77, "R6 failed write");
        fail_next = 0;
        ext_status = 8'h30;
        rd_expect(3'd1, 0, 32'h31, "R6 R7 sticky after write fail");
        repeat (3) @(negedge clk);
        chk("R5 all responses seen", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule